// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked system and an external asynchronous static RAM with a 17-bit word address and an 8-bit data bus. The system offers one request at a time with a valid/ready handshake. Each request carries an address, a write flag and, for writes, a data byte. The sequencer then plays out the pin pattern the RAM needs. When a read finishes, the captured byte is returned with a one-cycle done pulse. When a write finishes, the same pulse marks completion.

All RAM timing is counted in clock cycles derived at elaboration from a clock-period parameter. The nanosecond limits (cycle time, access times, pulse width, data overlap, release time) are parameters. Each count is the nanosecond figure divided by the clock period, rounded up, and never less than one. The data bus is split into an output byte, an input byte and a drive enable, so the pad tristate lives outside the block. The controller drives the bus only while writing and keeps the RAM's output enable high for the whole write.

With the default 10 ns clock, a read holds the RAM selected for 7 cycles and then waits 4 cycles for the RAM to release the bus. A write takes 1 setup cycle, then a 6-cycle write-enable low pulse, then 1 hold cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset the RAM is deselected (first enable `mem_ce_n`=1, second enable `mem_ce2`=0). Write enable and output enable are high, the bus drive enable is low, `req_ready`=1 and `rsp_done`=0.
- R2: While `req_ready` is high, the RAM stays deselected, write enable and output enable are high and the bus is not driven.
- R3: During a read the RAM is selected with output enable low, write enable high and the bus drive enable low.
- R4: A read accepted at clock edge k raises `rsp_done` for exactly one cycle after edge k+RD, where RD = max(ceil(70/CLK_NS), ceil(50/CLK_NS)). `rsp_rdata` then holds the byte stored at the requested address.
- R5: During a write, output enable stays high and the bus is driven for the whole operation. Write enable goes low for exactly WP = max(ceil(50/CLK_NS), ceil(30/CLK_NS), ceil(70/CLK_NS)-1, ceil(70/CLK_NS)-2) consecutive cycles, and the RAM is selected throughout.
- R6: A write accepted at edge k stores the request byte at the request address and raises `rsp_done` for one cycle after edge k+WP+2.
- R7: The RAM address changes only while write enable is high and was high in the previous cycle. The address is held for the whole operation.
- R8: After output enable rises, the bus drive enable stays low for at least ceil(35/CLK_NS) cycles.
- R9: While `req_ready` is low, requests are not accepted. A request withdrawn before ready returns leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Last byte read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | RAM address pins |
| mem_dq_out | output | 8 | Byte driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 8 | Byte seen on the data pads |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
Pin levels are registered from the next state, so they change on the acceptance edge itself. Read done is due RD edges after acceptance and write done WP+2 edges after acceptance; the bench counts falling edges from the acceptance edge and expects done on exactly that count. Inputs change and outputs are sampled on falling edges, so each sample reflects the registers after the preceding rising edge. Pulse widths, address changes and the bus-release gap are measured by a pin watcher that counts falling-edge samples.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACC,
      ST_RD_REL,
      ST_WR_SET,
      ST_WR_PULSE,
      ST_WR_HOLD
   } ctl_state_e;

   typedef struct packed {
      logic ce_n;
      logic ce2;
      logic we_n;
      logic oe_n;
      logic dq_oe;
   } pin_ctl_t;

   function automatic int cyc_of(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic pin_ctl_t pins_for(input ctl_state_e st);
      pin_ctl_t p;
      p = '{ce_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
      case (st)
         ST_RD_ACC: begin
            p.ce_n = 1'b0; p.ce2 = 1'b1; p.oe_n = 1'b0;
         end
         ST_WR_SET, ST_WR_HOLD: begin
            p.ce_n = 1'b0; p.ce2 = 1'b1; p.dq_oe = 1'b1;
         end
         ST_WR_PULSE: begin
            p.ce_n = 1'b0; p.ce2 = 1'b1; p.dq_oe = 1'b1; p.we_n = 1'b0;
         end
         default: ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_tick_counter.sv
module sram_tick_counter #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          last
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load)             cnt_q <= load_val;
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q <= CW'(1));

   p_load_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val != '0));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic              wr_fin,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         done <= 1'b0;
      end else begin
         if (sample) dout <= din;
         done <= sample | wr_fin;
      end
   end

   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_one_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample && wr_fin));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int CLK_NS = 10,
   parameter int T_RC   = 70,
   parameter int T_AA   = 70,
   parameter int T_OE   = 50,
   parameter int T_WC   = 70,
   parameter int T_WP   = 50,
   parameter int T_AW   = 70,
   parameter int T_DW   = 30,
   parameter int T_OHZ  = 35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_ce_n,
   output logic              mem_ce2,
   output logic              mem_we_n,
   output logic              mem_oe_n
);
   localparam int RD_N  = imax(imax(cyc_of(T_RC, CLK_NS), cyc_of(T_AA, CLK_NS)),
                               cyc_of(T_OE, CLK_NS));
   localparam int WP_N  = imax(imax(cyc_of(T_WP, CLK_NS), cyc_of(T_DW, CLK_NS)),
                               imax(cyc_of(T_AW, CLK_NS) - 1, cyc_of(T_WC, CLK_NS) - 2));
   localparam int OHZ_N = cyc_of(T_OHZ, CLK_NS);
   localparam int CNT_MAX = imax(imax(RD_N, WP_N), OHZ_N);
   localparam int CW = $clog2(CNT_MAX + 1) + 1;
   localparam logic [CW-1:0] LD_RD  = CW'(RD_N);
   localparam logic [CW-1:0] LD_WP  = CW'(WP_N);
   localparam logic [CW-1:0] LD_OHZ = CW'(OHZ_N);
   localparam logic [CW-1:0] LD_ONE = CW'(1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("CLK_NS must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("address and data widths must be positive");
   end

   ctl_state_e state_q, state_d;
   pin_ctl_t   pins_q;
   logic       ld, last, sample, wr_fin;
   logic [CW-1:0] ld_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic accept;

   assign accept = req_valid && (state_q == ST_IDLE);

   always_comb begin
      state_d = state_q;
      ld      = 1'b0;
      ld_val  = LD_ONE;
      sample  = 1'b0;
      wr_fin  = 1'b0;
      case (state_q)
         ST_IDLE: if (req_valid) begin
            ld = 1'b1;
            if (req_write) begin
               state_d = ST_WR_SET;
               ld_val  = LD_ONE;
            end else begin
               state_d = ST_RD_ACC;
               ld_val  = LD_RD;
            end
         end
         ST_RD_ACC: if (last) begin
            sample  = 1'b1;
            state_d = ST_RD_REL;
            ld      = 1'b1;
            ld_val  = LD_OHZ;
         end
         ST_RD_REL: if (last) state_d = ST_IDLE;
         ST_WR_SET: if (last) begin
            state_d = ST_WR_PULSE;
            ld      = 1'b1;
            ld_val  = LD_WP;
         end
         ST_WR_PULSE: if (last) begin
            state_d = ST_WR_HOLD;
            ld      = 1'b1;
            ld_val  = LD_ONE;
         end
         ST_WR_HOLD: if (last) begin
            state_d = ST_IDLE;
            wr_fin  = 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pins_q  <= pins_for(ST_IDLE);
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         pins_q  <= pins_for(state_d);
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
      end
   end

   sram_tick_counter #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .last     (last)
   );

   sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (sample),
      .wr_fin (wr_fin),
      .din    (mem_dq_in),
      .dout   (rsp_rdata),
      .done   (rsp_done)
   );

   assign req_ready  = (state_q == ST_IDLE);
   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
   assign mem_dq_oe  = pins_q.dq_oe;
   assign mem_ce_n   = pins_q.ce_n;
   assign mem_ce2    = pins_q.ce2;
   assign mem_we_n   = pins_q.we_n;
   assign mem_oe_n   = pins_q.oe_n;

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

   p_read_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_ce2 && mem_we_n && !mem_dq_oe));

   p_write_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_ce2 && mem_oe_n && mem_dq_oe));

   p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

   p_addr_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));

   p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && req_valid) |=> $stable(mem_addr));

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
   localparam int CLK_NS = 10;
   localparam int E_RD  = 7;   // max(ceil(70/10), ceil(50/10))
   localparam int E_WP  = 6;   // max(5, 3, 7-1, 7-2)
   localparam int E_OHZ = 4;   // ceil(35/10)

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic req_ready, rsp_done, mem_dq_oe, mem_ce_n, mem_ce2, mem_we_n, mem_oe_n;
   logic [7:0]  rsp_rdata, mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;
   logic [16:0] mem_addr;

   int n_chk = 0, n_fail = 0;
   logic [7:0] sram_arr [int];
   logic [7:0] ref_arr [int];

   always #(CLK_NS/2) clk = ~clk;

   sram_async_ctrl #(.CLK_NS(CLK_NS)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
      .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
   );

   function automatic logic [7:0] dflt(input logic [16:0] a);
      return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h3C;
   endfunction

   function automatic logic [7:0] ref_rd(input logic [16:0] a);
      if (ref_arr.exists(int'(a))) return ref_arr[int'(a)];
      return dflt(a);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // RAM model and pin watcher, all on falling edges
   logic sel;
   assign sel = !mem_ce_n && mem_ce2;
   int we_run = 0, oe_hi = 1000;
   logic [16:0] prev_addr = '0;
   logic prev_we = 1'b1, prev_oe_drv = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (sel && !mem_we_n) sram_arr[int'(mem_addr)] = mem_dq_out;
         if (sel && mem_we_n && !mem_oe_n)
            mem_dq_in <= sram_arr.exists(int'(mem_addr)) ? sram_arr[int'(mem_addr)] : dflt(mem_addr);
         else
            mem_dq_in <= 8'hEE;
         // R5 pulse width
         if (!mem_we_n) we_run++;
         else if (we_run > 0) begin
            check(we_run == E_WP, "R5 we low width", we_run, E_WP);
            we_run = 0;
         end
         // R7 address changes only with write enable high
         if (mem_addr != prev_addr)
            check(mem_we_n && prev_we, "R7 addr moved with we low", {mem_we_n, prev_we}, 3);
         // R8 release gap before driving
         if (mem_dq_oe && !prev_oe_drv)
            check(oe_hi >= E_OHZ, "R8 bus turnaround gap", oe_hi, E_OHZ);
         if (mem_dq_oe && !mem_oe_n)
            check(1'b0, "R5 bus driven with oe low", 1, 0);
         if (!mem_oe_n) oe_hi = 0;
         else if (!mem_dq_oe) oe_hi++;
         prev_addr = mem_addr;
         prev_we = mem_we_n;
         prev_oe_drv = mem_dq_oe;
      end
   end

   task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
      int j;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (wr) check(mem_dq_oe && mem_oe_n, "R5 write pins", {mem_dq_oe, mem_oe_n}, 3);
      else check(!mem_oe_n && mem_we_n && !mem_dq_oe && sel, "R3 read pins",
                 {mem_oe_n, mem_we_n, mem_dq_oe, sel}, 4'b0101);
      j = 0;
      while (!rsp_done && j < 50) begin
         @(negedge clk);
         j++;
      end
      if (wr) begin
         check(j == E_WP + 2, "R6 write done latency", j, E_WP + 2);
         ref_arr[int'(a)] = d;
      end else begin
         check(j == E_RD, "R4 read done latency", j, E_RD);
         check(rsp_rdata == ref_rd(a), "R4 read data", rsp_rdata, ref_rd(a));
      end
      @(negedge clk);
      check(!rsp_done, "R4 done one cycle", rsp_done, 0);
      while (!req_ready) @(negedge clk);
      check(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R2 idle pins",
            {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd41));
      repeat (3) @(negedge clk);
      check(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_done,
            "R1 reset state", {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_done},
            7'b1011010);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && mem_ce_n, "R1 ready after reset", {req_ready, mem_ce_n}, 3);

      // directed corners: lowest and highest word, read of unwritten word
      do_op(1'b0, 17'h00000, 8'h00);
      do_op(1'b1, 17'h00000, 8'hA5);
      do_op(1'b0, 17'h00000, 8'h00);
      do_op(1'b1, 17'h1FFFF, 8'h5A);
      do_op(1'b0, 17'h1FFFF, 8'h00);
      do_op(1'b1, 17'h1FFFF, 8'hFF);   // write right after read: R8 gap
      do_op(1'b0, 17'h1FFFF, 8'h00);

      // R9: request offered and withdrawn while busy
      begin
         int j;
         req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00010;
         @(posedge clk);
         @(negedge clk);
         req_write = 1'b1; req_addr = 17'h00020; req_wdata = ~ref_rd(17'h00020);
         check(!req_ready, "R9 ready low while busy", req_ready, 0);
         @(negedge clk);
         @(negedge clk);
         req_valid = 1'b0;
         j = 0;
         while (!req_ready && j < 50) begin
            @(negedge clk);
            j++;
         end
         check(rsp_rdata == ref_rd(17'h00010), "R9 first read intact", rsp_rdata, ref_rd(17'h00010));
         do_op(1'b0, 17'h00020, 8'h00);  // must still hold the old byte
      end

      // constrained random mix
      for (int i = 0; i < 80; i++) begin
         logic [16:0] a;
         int sel_a;
         sel_a = int'($urandom % 4);
         case (sel_a)
            0: a = 17'h00000;
            1: a = 17'h1FFFF;
            2: a = 17'($urandom % 16);
            default: a = 17'($urandom);
         endcase
         do_op(1'($urandom % 2), a, 8'($urandom));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule